// File: doc/BRIEF.md
# Supervisor Timer Compare Interrupt Unit

This unit keeps two 64-bit timer compare values, one for the supervisor level and one for the virtual-supervisor level. It raises a timer pending bit for each. The supervisor bit is set when the platform time is at or past its compare value. The virtual-supervisor bit is set when the time plus a hypervisor offset is at or past its compare value. Both bits are levels, so they clear again when the compared quantity falls below the compare value.

The bits are not recomputed on every cycle. They are re-evaluated when the time source signals an update, and when software writes a compare register. A write is judged at once against the current time, using the value just written. The result of either event appears one cycle later.

Software reaches the compare registers through a small CSR write port with readback. With a 32-bit register width, each compare register splits into a low half and a high half at separate addresses. The unit also supplies the write-mask contribution that tells the pending register whether software may write the supervisor timer bit.

Top module: `tcmp_unit`

## Requirements
- R1: On a cycle with `time_upd_i` high and no supervisor compare write, `s_pend_o` in the following cycle equals (`time_i` >= supervisor compare).
- R2: On a time update, `vs_pend_o` in the following cycle equals ((`time_i` + `delta_i`) mod 2^64 >= virtual-supervisor compare).
- R3: When there is neither a time update nor a write to its own compare register, a pending bit holds its value, whatever `time_i` or `delta_i` do.
- R4: A write to a compare register re-evaluates only that register's pending bit, against the present `time_i` (plus `delta_i` for the virtual-supervisor bit), using the merged new value. The result is visible in the cycle after the write.
- R5: `pend_wmask_o` has bit 5, the supervisor timer position, set exactly when `tce_i` is 0. All its other bits are 0.
- R6: Register addresses are 0x14D and 0x24D for the low part of the supervisor and virtual-supervisor compares, and 0x15D and 0x25D for the high halves. With XLEN=32, a low write replaces bits 31:0 and a high write replaces bits 63:32, leaving the other half intact. With XLEN=64, the low address carries all 64 bits, and the high addresses are neither written nor readable (they read 0). `rd_data_o` is combinational from `rd_addr_i`, and unknown addresses read 0.
- R7: A synchronous reset clears both compare registers and both pending bits.
- R8: All comparisons are unsigned over 64 bits.
- R9: With ENABLE=0, compare writes are ignored (readback is 0), both pending bits stay low, and bit 5 of `pend_wmask_o` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | 64 | Current platform time |
| time_upd_i | input | 1 | Time value updated this cycle |
| delta_i | input | 64 | Hypervisor time offset |
| tce_i | input | 1 | Timer-compare enable from machine environment config |
| wr_en_i | input | 1 | CSR write strobe |
| wr_addr_i | input | 12 | CSR write address |
| wr_data_i | input | XLEN | CSR write data |
| rd_addr_i | input | 12 | CSR read address |
| rd_data_o | output | XLEN | CSR readback data |
| s_pend_o | output | 1 | Supervisor timer pending |
| vs_pend_o | output | 1 | Virtual-supervisor timer pending |
| pend_wmask_o | output | XLEN | Software write-mask contribution for the pending register |

## Verification
The level checks assume that `time_i` is stable on any cycle where `time_upd_i` is high. They also assume that a write and a time update may coincide, so the supervisor check is only required on update cycles without a supervisor compare write. The hold check assumes that `delta_i` and `time_i` may drift freely between updates. The stimulus exercises this by changing `time_i` without the strobe. Every input is driven on the falling edge, and it presents at most one write per cycle, as the single port implies.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    typedef logic [63:0] tval_t;
    typedef logic [11:0] caddr_t;

    typedef enum logic [0:0] {
        CH_SUP  = 1'b0,
        CH_VSUP = 1'b1
    } chan_e;

    localparam int     NCH       = 2;
    localparam int     STIP_POS  = 5;
    localparam caddr_t A_SUP_LO  = 12'h14D;
    localparam caddr_t A_SUP_HI  = 12'h15D;
    localparam caddr_t A_VSUP_LO = 12'h24D;
    localparam caddr_t A_VSUP_HI = 12'h25D;

    function automatic logic is_due(input tval_t now, input tval_t cmp);
        return now >= cmp;
    endfunction

    function automatic tval_t shifted_time(input tval_t now, input tval_t off);
        return now + off;
    endfunction

endpackage

// File: rtl/tcmp_cmp_reg.sv
module tcmp_cmp_reg
    import tcmp_pkg::*;
#(
    parameter int     XLEN    = 64,
    parameter bit     ENABLE  = 1'b1,
    parameter caddr_t LO_ADDR = A_SUP_LO,
    parameter caddr_t HI_ADDR = A_SUP_HI
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  caddr_t          wr_addr,
    input  logic [XLEN-1:0] wr_data,
    output tval_t           cmp_q,
    output tval_t           cmp_nx,
    output logic            hit
);

    logic hit_lo;
    logic hit_hi;

    assign hit_lo = ENABLE && wr_en && (wr_addr == LO_ADDR);

    generate
        if (XLEN == 32) begin : g_half
            assign hit_hi = ENABLE && wr_en && (wr_addr == HI_ADDR);
            always_comb begin
                cmp_nx = cmp_q;
                if (hit_lo) cmp_nx[31:0]  = wr_data[31:0];
                if (hit_hi) cmp_nx[63:32] = wr_data[31:0];
            end

            AST_HALF_KEEP_HI: assert property (@(posedge clk) disable iff (rst)
                hit_lo && !hit_hi |=> cmp_q[63:32] == $past(cmp_q[63:32])); // R6
            AST_HALF_KEEP_LO: assert property (@(posedge clk) disable iff (rst)
                hit_hi && !hit_lo |=> cmp_q[31:0] == $past(cmp_q[31:0])); // R6
        end else begin : g_full
            assign hit_hi = 1'b0;
            always_comb begin
                cmp_nx = cmp_q;
                if (hit_lo) cmp_nx = tval_t'(wr_data);
            end
        end
    endgenerate

    assign hit = hit_lo || hit_hi;

    always_ff @(posedge clk) begin
        if (rst)      cmp_q <= '0;
        else if (hit) cmp_q <= cmp_nx;
    end

    AST_CMP_RESET: assert property (@(posedge clk)
        rst |=> cmp_q == '0); // R7
    AST_CMP_NOWRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cmp_q)); // R3

endmodule

// File: rtl/tcmp_pend.sv
module tcmp_pend
    import tcmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  eval,
    input  tval_t now,
    input  tval_t cmp,
    output logic  pend_q
);

    always_ff @(posedge clk) begin
        if (rst)              pend_q <= 1'b0;
        else if (en && eval)  pend_q <= is_due(now, cmp);
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eval |=> $stable(pend_q)); // R3

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int     XLEN      = 64,
    parameter bit     ENABLE    = 1'b1,
    parameter caddr_t SUP_LO    = A_SUP_LO,
    parameter caddr_t SUP_HI    = A_SUP_HI,
    parameter caddr_t VSUP_LO   = A_VSUP_LO,
    parameter caddr_t VSUP_HI   = A_VSUP_HI
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [63:0]     time_i,
    input  logic            time_upd_i,
    input  logic [63:0]     delta_i,
    input  logic            tce_i,
    input  logic            wr_en_i,
    input  logic [11:0]     wr_addr_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic [11:0]     rd_addr_i,
    output logic [XLEN-1:0] rd_data_o,
    output logic            s_pend_o,
    output logic            vs_pend_o,
    output logic [XLEN-1:0] pend_wmask_o
);

    localparam bit HALVES = (XLEN == 32);

    tval_t cmp_q   [NCH];
    tval_t cmp_nx  [NCH];
    tval_t now_v   [NCH];
    logic  hit     [NCH];
    logic  pend    [NCH];

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_ch
            localparam caddr_t LO = (ch == int'(CH_SUP)) ? SUP_LO : VSUP_LO;
            localparam caddr_t HI = (ch == int'(CH_SUP)) ? SUP_HI : VSUP_HI;

            if (ch == int'(CH_SUP)) begin : g_now_s
                assign now_v[ch] = time_i;
            end else begin : g_now_v
                assign now_v[ch] = shifted_time(time_i, delta_i);
            end

            tcmp_cmp_reg #(
                .XLEN    (XLEN),
                .ENABLE  (ENABLE),
                .LO_ADDR (LO),
                .HI_ADDR (HI)
            ) u_reg (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_en_i),
                .wr_addr (wr_addr_i),
                .wr_data (wr_data_i),
                .cmp_q   (cmp_q[ch]),
                .cmp_nx  (cmp_nx[ch]),
                .hit     (hit[ch])
            );

            tcmp_pend u_pend (
                .clk    (clk),
                .rst    (rst),
                .en     (ENABLE),
                .eval   (time_upd_i || hit[ch]),
                .now    (now_v[ch]),
                .cmp    (cmp_nx[ch]),
                .pend_q (pend[ch])
            );
        end
    endgenerate

    assign s_pend_o  = pend[CH_SUP];
    assign vs_pend_o = pend[CH_VSUP];

    always_comb begin
        pend_wmask_o           = '0;
        pend_wmask_o[STIP_POS] = !(ENABLE && tce_i);
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == SUP_LO)
            rd_data_o = XLEN'(cmp_q[CH_SUP]);
        else if (rd_addr_i == VSUP_LO)
            rd_data_o = XLEN'(cmp_q[CH_VSUP]);
        else if (HALVES && rd_addr_i == SUP_HI)
            rd_data_o = XLEN'(cmp_q[CH_SUP] >> 32);
        else if (HALVES && rd_addr_i == VSUP_HI)
            rd_data_o = XLEN'(cmp_q[CH_VSUP] >> 32);
    end

    generate
        if (ENABLE) begin : g_chk_on
            AST_SUP_LEVEL: assert property (@(posedge clk) disable iff (rst)
                time_upd_i && !hit[CH_SUP] |=>
                s_pend_o == ($past(time_i) >= $past(cmp_q[CH_SUP]))); // R1
            AST_VSUP_LEVEL: assert property (@(posedge clk) disable iff (rst)
                time_upd_i && !hit[CH_VSUP] |=>
                vs_pend_o == (($past(time_i) + $past(delta_i)) >= $past(cmp_q[CH_VSUP]))); // R2
            AST_WRITE_ONLY_OWN: assert property (@(posedge clk) disable iff (rst)
                hit[CH_SUP] && !time_upd_i |=> $stable(vs_pend_o)); // R4
        end else begin : g_chk_off
            AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
                time_upd_i || wr_en_i |=> !s_pend_o && !vs_pend_o); // R9
        end
    endgenerate

endmodule

// File: tb/sim_tcmp_unit.sv
module sim_tcmp_unit;
    import tcmp_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic [63:0] time_i = '0;
    logic        upd = 1'b0;
    logic [63:0] delta = '0;
    logic        tce = 1'b0;

    logic        w0_en = 1'b0;
    logic [11:0] w0_addr = '0;
    logic [31:0] w0_data = '0;
    logic [11:0] r0_addr = '0;
    logic [31:0] r0_data;
    logic        s0, v0;
    logic [31:0] m0;

    logic        w1_en = 1'b0;
    logic [11:0] w1_addr = '0;
    logic [63:0] w1_data = '0;
    logic [11:0] r1_addr = '0;
    logic [63:0] r1_data, r2_data;
    logic        s1, v1, s2, v2;
    logic [63:0] m1, m2;

    tcmp_unit #(.XLEN(32)) u0 (
        .clk(clk), .rst(rst), .time_i(time_i), .time_upd_i(upd), .delta_i(delta),
        .tce_i(tce), .wr_en_i(w0_en), .wr_addr_i(w0_addr), .wr_data_i(w0_data),
        .rd_addr_i(r0_addr), .rd_data_o(r0_data), .s_pend_o(s0), .vs_pend_o(v0),
        .pend_wmask_o(m0));

    tcmp_unit #(.XLEN(64)) u1 (
        .clk(clk), .rst(rst), .time_i(time_i), .time_upd_i(upd), .delta_i(delta),
        .tce_i(tce), .wr_en_i(w1_en), .wr_addr_i(w1_addr), .wr_data_i(w1_data),
        .rd_addr_i(r1_addr), .rd_data_o(r1_data), .s_pend_o(s1), .vs_pend_o(v1),
        .pend_wmask_o(m1));

    tcmp_unit #(.XLEN(64), .ENABLE(1'b0)) u2 (
        .clk(clk), .rst(rst), .time_i(time_i), .time_upd_i(upd), .delta_i(delta),
        .tce_i(tce), .wr_en_i(w1_en), .wr_addr_i(w1_addr), .wr_data_i(w1_data),
        .rd_addr_i(r1_addr), .rd_data_o(r2_data), .s_pend_o(s2), .vs_pend_o(v2),
        .pend_wmask_o(m2));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic step_time(input logic [63:0] t);
        time_i = t; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic wr0(input logic [11:0] a, input logic [31:0] d);
        w0_en = 1'b1; w0_addr = a; w0_data = d;
        @(negedge clk);
        w0_en = 1'b0;
    endtask

    task automatic wr1(input logic [11:0] a, input logic [63:0] d);
        w1_en = 1'b1; w1_addr = a; w1_data = d;
        @(negedge clk);
        w1_en = 1'b0;
    endtask

    task automatic rd0(input logic [11:0] a, input string req, input logic [31:0] exp);
        r0_addr = a; #1;
        check(req, 64'(r0_data), 64'(exp));
    endtask

    task automatic t_reset;
        check("R7 s_pend after reset", 64'(s0), 0);
        check("R7 vs_pend after reset", 64'(v0), 0);
        rd0(A_SUP_LO, "R7 sup lo after reset", 0);
        rd0(A_SUP_HI, "R7 sup hi after reset", 0);
        rd0(A_VSUP_LO, "R7 vsup lo after reset", 0);
        rd0(A_VSUP_HI, "R7 vsup hi after reset", 0);
    endtask

    task automatic t_sup_level;
        wr0(A_SUP_LO, 32'd100);
        check("R4 write above time", 64'(s0), 0);
        step_time(64'd99);  check("R1 below compare", 64'(s0), 0);
        step_time(64'd100); check("R1 equal compare", 64'(s0), 1);
        step_time(64'd150); check("R1 above compare", 64'(s0), 1);
        step_time(64'd50);  check("R1 level clears", 64'(s0), 0);
    endtask

    task automatic t_vsup_wrap;
        delta = 64'hFFFF_FFFF_FFFF_FFF0;
        wr0(A_VSUP_LO, 32'd5);
        check("R4 vsup write sum 0x22>=5", 64'(v0), 1);
        step_time(64'h12); check("R2 wrapped sum 2<5", 64'(v0), 0);
        check("R1 sup stays low", 64'(s0), 0);
        step_time(64'h20); check("R2 wrapped sum 0x10>=5", 64'(v0), 1);
        step_time(64'h12); check("R2 back below", 64'(v0), 0);
    endtask

    task automatic t_write_eval;
        wr0(A_VSUP_LO, 32'd1);
        check("R4 vsup new value 1 vs sum 2", 64'(v0), 1);
        check("R4 sup untouched by vsup write", 64'(s0), 0);
        wr0(A_SUP_LO, 32'h10);
        check("R4 sup new value 0x10 vs 0x12", 64'(s0), 1);
        check("R4 vsup untouched by sup write", 64'(v0), 1);
    endtask

    task automatic t_hold;
        time_i = 64'd0;
        delta  = 64'd0;
        repeat (3) @(negedge clk);
        check("R3 sup holds without update", 64'(s0), 1);
        check("R3 vsup holds without update", 64'(v0), 1);
        wr0(12'h100, 32'hFFFF_FFFF);
        check("R3 foreign address write sup", 64'(s0), 1);
        check("R3 foreign address write vsup", 64'(v0), 1);
        rd0(12'h100, "R6 unknown address reads 0", 0);
    endtask

    task automatic t_halves;
        wr0(A_SUP_HI, 32'hDEAD_BEEF);
        check("R4 merged high write re-evaluates", 64'(s0), 0);
        rd0(A_SUP_LO, "R6 low kept after high write", 32'h10);
        rd0(A_SUP_HI, "R6 high written", 32'hDEAD_BEEF);
        wr0(A_SUP_LO, 32'h1234);
        rd0(A_SUP_HI, "R6 high kept after low write", 32'hDEAD_BEEF);
        rd0(A_SUP_LO, "R6 low written", 32'h1234);
        step_time(64'hDEAD_BEEF_0000_1233); check("R1 one below 64-bit compare", 64'(s0), 0);
        step_time(64'hDEAD_BEEF_0000_1234); check("R1 equal 64-bit compare", 64'(s0), 1);
        step_time(64'h7FFF_FFFF_FFFF_FFFF); check("R8 unsigned compare", 64'(s0), 0);
    endtask

    task automatic t_mask;
        tce = 1'b0; #1;
        check("R5 mask writable", 64'(m0), 64'h20);
        tce = 1'b1; #1;
        check("R5 mask locked", 64'(m0), 64'h0);
        check("R9 disabled mask always writable", m2, 64'h20);
        tce = 1'b0; #1;
    endtask

    task automatic t_full_width;
        delta = 64'd0;
        wr1(A_SUP_LO, 64'h1_0000_0000);
        step_time(64'hFFFF_FFFF);    check("R1 xlen64 below", 64'(s1), 0);
        step_time(64'h1_0000_0000);  check("R1 xlen64 equal", 64'(s1), 1);
        check("R9 disabled sup stays low", 64'(s2), 0);
        wr1(A_SUP_HI, 64'd5);
        r1_addr = A_SUP_LO; #1;
        check("R6 xlen64 high address not decoded", r1_data, 64'h1_0000_0000);
        check("R9 disabled readback zero", r2_data, 64'h0);
        r1_addr = A_SUP_HI; #1;
        check("R6 xlen64 high address reads 0", r1_data, 64'h0);
        wr1(A_VSUP_LO, 64'd0);
        check("R4 xlen64 vsup zero compare", 64'(v1), 1);
        check("R9 disabled vsup stays low", 64'(v2), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sup_level();
        t_vsup_wrap();
        t_write_eval();
        t_hold();
        t_halves();
        t_mask();
        t_full_width();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule